// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block watches the sampled bits of a CAN node and decides whether a protocol error has occurred. At each sample strobe it compares the bit the node drove with the bit it read back, examines the fixed-form fields, the ACK slot and the stuffing hints from the receive path, and accepts a CRC verdict from the frame checker. Every error class has its own exception rules and its own one-cycle flag.

The detected errors drive two saturating 8-bit counters, one for transmit trouble and one for receive trouble. Transmit errors weigh eight times as much as receive errors. A long dominant run penalises both counters, and each successful frame earns one point back. From the two counters the unit derives the node state: error-active, error-passive or bus-off. A frame controller uses the flags to start error signalling and uses the state to decide whether it may still drive active error flags. It does not generate error frames and does not run the bus-off recovery sequence.

Top module: `can_fault_conf`

## Requirements
- R1: When `smp` is high, `tx_active` is high and `tx_bit` differs from `rx_bit`, `bit_err` pulses high for exactly one cycle, on the clock edge after that sample. No bit error is flagged while `in_arb` or `in_ack_slot` is high, or when `smp` is low.
- R2: `stuff_err` pulses one cycle after a sample where `six_same` is high and `stuff_drop` is low. There is no pulse when `stuff_drop` is high.
- R3: `crc_err` pulses one cycle after `crc_chk` is high with `crc_ok` low. There is no pulse when `crc_ok` is high. This check does not need `smp`.
- R4: `form_err` pulses one cycle after a sample where `rx_bit` is 0 (dominant) while any of `in_crc_delim`, `in_ack_delim` or `in_eof` is high. A recessive bit (1) in those fields raises no flag.
- R5: `ack_err` pulses one cycle after a sample where `tx_active` and `in_ack_slot` are high and `rx_bit` is 1 (recessive).
- R6: A sample that carries at least one error while `tx_active` is high adds 8 to `tec`. `tec` saturates at 255.
- R7: A sample that carries at least one error while `tx_active` is low adds 1 to `rec`. `rec` saturates at 255.
- R8: A run of 14 consecutive dominant samples adds 8 to both counters, and the run count then starts again. Any recessive sample restarts the run.
- R9: A dominant sample taken while `post_flag` is high adds 8 to `rec`.
- R10: `tx_ok` subtracts 1 from `tec` and `rx_ok` subtracts 1 from `rec`. Neither counter goes below 0. Neither counter falls except on its success strobe.
- R11: Exactly one of `err_active`, `err_passive` and `bus_off` is high. `bus_off` is high when `tec` is 255. Otherwise `err_passive` is high when either counter is 128 or more. Otherwise `err_active` is high.
- R12: All events in one cycle combine into a single net update of each counter. Several error classes in one sample count as one error. The counter is clamped to the range 0 to 255 after the additions and the subtraction.
- R13: After a synchronous active-high `rst`, both counters are 0, all error flags are low and `err_active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp | input | 1 | Bit sample strobe |
| tx_bit | input | 1 | Bit driven by this node (0 = dominant) |
| rx_bit | input | 1 | Bit read from the bus (0 = dominant) |
| tx_active | input | 1 | Node is the transmitter of the current frame |
| in_arb | input | 1 | Current bit lies in the arbitration field |
| in_ack_slot | input | 1 | Current bit is the ACK slot |
| in_crc_delim | input | 1 | Current bit is the CRC delimiter |
| in_ack_delim | input | 1 | Current bit is the ACK delimiter |
| in_eof | input | 1 | Current bit lies in end-of-frame |
| six_same | input | 1 | Receive path has seen six equal bits in a row |
| stuff_drop | input | 1 | Receive path removed a stuff bit at this sample |
| crc_ok | input | 1 | Received CRC matches the computed one |
| crc_chk | input | 1 | Strobe: `crc_ok` is valid |
| post_flag | input | 1 | Current bit follows this node's own error flag |
| tx_ok | input | 1 | Strobe: frame transmitted successfully |
| rx_ok | input | 1 | Strobe: frame received successfully |
| bit_err | output | 1 | Bit error pulse |
| stuff_err | output | 1 | Stuff error pulse |
| form_err | output | 1 | Form error pulse |
| ack_err | output | 1 | ACK error pulse |
| crc_err | output | 1 | CRC error pulse |
| tec | output | 8 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| err_active | output | 1 | Node is error-active |
| err_passive | output | 1 | Node is error-passive |
| bus_off | output | 1 | Node is bus-off |

## Verification
The checks on flag sources assume that each strobe (`smp`, `crc_chk`, `tx_ok`, `rx_ok`) is meaningful only in the cycle it is high. They also assume that the field qualifiers describe the bit sampled in that same cycle. The stimulus holds each qualifier for a single sampled cycle and returns every input to its idle, recessive level right after. Each scenario starts from reset, so no dominant run is carried over from an earlier scenario. Bit errors in the saturation tests use a dominant drive with a recessive read-back. These samples never add to the dominant-run count, so the expected counter values stay exact.

// File: rtl/cfc_pkg.sv
`timescale 1ns/1ps
package cfc_pkg;

    typedef enum logic [1:0] {
        NODE_ACTIVE  = 2'd0,
        NODE_PASSIVE = 2'd1,
        NODE_BUSOFF  = 2'd2
    } node_state_e;

    // one bit per detected error class, same sample
    typedef struct packed {
        logic bit_e;
        logic stuff_e;
        logic form_e;
        logic ack_e;
        logic crc_e;
    } err_hits_t;

    // bus-level penalty events that are not error classes
    typedef struct packed {
        logic run_hit;
        logic flag_dom;
    } bus_evt_t;

    localparam int unsigned TEC_I = 0;
    localparam int unsigned REC_I = 1;
    localparam int unsigned N_CNT = 2;

    function automatic logic any_hit(err_hits_t h);
        return |h;
    endfunction

endpackage

// File: rtl/cfc_detect.sv
`timescale 1ns/1ps
module cfc_detect
    import cfc_pkg::*;
#(
    parameter int unsigned RUN_LEN = 14
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      smp,
    input  logic      tx_bit,
    input  logic      rx_bit,
    input  logic      tx_active,
    input  logic      in_arb,
    input  logic      in_ack_slot,
    input  logic      in_crc_delim,
    input  logic      in_ack_delim,
    input  logic      in_eof,
    input  logic      six_same,
    input  logic      stuff_drop,
    input  logic      crc_ok,
    input  logic      crc_chk,
    input  logic      post_flag,
    output err_hits_t hit,
    output bus_evt_t  evt,
    output err_hits_t hit_q
);
    localparam int unsigned RUN_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

    logic [RUN_W-1:0] run_q;
    logic             fixed_field;

    always_comb begin
        fixed_field   = in_crc_delim | in_ack_delim | in_eof;
        hit.bit_e     = smp & tx_active & ~in_arb & ~in_ack_slot & (tx_bit ^ rx_bit);
        hit.stuff_e   = smp & six_same & ~stuff_drop;
        hit.form_e    = smp & ~rx_bit & fixed_field;
        hit.ack_e     = smp & tx_active & in_ack_slot & rx_bit;
        hit.crc_e     = crc_chk & ~crc_ok;
        evt.run_hit   = smp & ~rx_bit & (run_q == RUN_LAST);
        evt.flag_dom  = smp & post_flag & ~rx_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            hit_q <= '0;
        end else begin
            hit_q <= hit;
            if (smp) begin
                if (rx_bit || run_q == RUN_LAST) run_q <= '0;
                else                             run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfc_satcnt.sv
`timescale 1ns/1ps
module cfc_satcnt #(
    parameter int unsigned W  = 8,
    parameter int unsigned AW = W + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] add,
    input  logic          dec,
    output logic [W-1:0]  q
);
    localparam int unsigned SW = AW + 1;
    localparam logic [SW-1:0] TOP = SW'((1 << W) - 1);

    logic [SW-1:0] sum;
    logic [SW-1:0] net;

    always_comb begin
        sum = SW'(q) + SW'(add);
        net = (dec && sum != '0) ? sum - SW'(1) : sum;
    end

    always_ff @(posedge clk) begin
        if (rst)            q <= '0;
        else if (net > TOP) q <= TOP[W-1:0];
        else                q <= net[W-1:0];
    end
endmodule

// File: rtl/cfc_state.sv
`timescale 1ns/1ps
module cfc_state
    import cfc_pkg::*;
#(
    parameter int unsigned W           = 8,
    parameter int unsigned PASSIVE_LIM = 128
) (
    input  logic [W-1:0] tec,
    input  logic [W-1:0] rec,
    output node_state_e  st
);
    localparam logic [W-1:0] LIM = W'(PASSIVE_LIM);
    localparam logic [W-1:0] TOP = '1;

    always_comb begin
        if (tec == TOP)                    st = NODE_BUSOFF;
        else if (tec >= LIM || rec >= LIM) st = NODE_PASSIVE;
        else                               st = NODE_ACTIVE;
    end
endmodule

// File: rtl/can_fault_conf.sv
`timescale 1ns/1ps
module can_fault_conf
    import cfc_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned PASSIVE_LIM = 128,
    parameter int unsigned TX_ERR_STEP = 8,
    parameter int unsigned RX_ERR_STEP = 1,
    parameter int unsigned RUN_LEN     = 14,
    parameter int unsigned RUN_STEP    = 8,
    parameter int unsigned FLAG_STEP   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp,
    input  logic             tx_bit,
    input  logic             rx_bit,
    input  logic             tx_active,
    input  logic             in_arb,
    input  logic             in_ack_slot,
    input  logic             in_crc_delim,
    input  logic             in_ack_delim,
    input  logic             in_eof,
    input  logic             six_same,
    input  logic             stuff_drop,
    input  logic             crc_ok,
    input  logic             crc_chk,
    input  logic             post_flag,
    input  logic             tx_ok,
    input  logic             rx_ok,
    output logic             bit_err,
    output logic             stuff_err,
    output logic             form_err,
    output logic             ack_err,
    output logic             crc_err,
    output logic [CNT_W-1:0] tec,
    output logic [CNT_W-1:0] rec,
    output logic             err_active,
    output logic             err_passive,
    output logic             bus_off
);
    localparam int unsigned ADD_W = CNT_W + 1;

    err_hits_t        hit;
    err_hits_t        hit_q;
    bus_evt_t         evt;
    logic             any_err;
    logic             tx_err;
    logic             rx_err;
    logic [ADD_W-1:0] add_v [N_CNT];
    logic             dec_v [N_CNT];
    logic [CNT_W-1:0] cnt_v [N_CNT];
    node_state_e      st;

    cfc_detect #(.RUN_LEN(RUN_LEN)) u_det (
        .clk          (clk),
        .rst          (rst),
        .smp          (smp),
        .tx_bit       (tx_bit),
        .rx_bit       (rx_bit),
        .tx_active    (tx_active),
        .in_arb       (in_arb),
        .in_ack_slot  (in_ack_slot),
        .in_crc_delim (in_crc_delim),
        .in_ack_delim (in_ack_delim),
        .in_eof       (in_eof),
        .six_same     (six_same),
        .stuff_drop   (stuff_drop),
        .crc_ok       (crc_ok),
        .crc_chk      (crc_chk),
        .post_flag    (post_flag),
        .hit          (hit),
        .evt          (evt),
        .hit_q        (hit_q)
    );

    // several classes in one sample count as a single error (R12)
    always_comb begin
        any_err = any_hit(hit);
        tx_err  = any_err & tx_active;
        rx_err  = any_err & ~tx_active;

        add_v[TEC_I] = (tx_err      ? ADD_W'(TX_ERR_STEP) : '0)
                     + (evt.run_hit ? ADD_W'(RUN_STEP)    : '0);
        add_v[REC_I] = (rx_err       ? ADD_W'(RX_ERR_STEP) : '0)
                     + (evt.run_hit  ? ADD_W'(RUN_STEP)    : '0)
                     + (evt.flag_dom ? ADD_W'(FLAG_STEP)   : '0);
        dec_v[TEC_I] = tx_ok;
        dec_v[REC_I] = rx_ok;
    end

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        cfc_satcnt #(.W(CNT_W), .AW(ADD_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .add (add_v[g]),
            .dec (dec_v[g]),
            .q   (cnt_v[g])
        );
    end

    assign tec = cnt_v[TEC_I];
    assign rec = cnt_v[REC_I];

    cfc_state #(.W(CNT_W), .PASSIVE_LIM(PASSIVE_LIM)) u_st (
        .tec (tec),
        .rec (rec),
        .st  (st)
    );

    assign err_active  = (st == NODE_ACTIVE);
    assign err_passive = (st == NODE_PASSIVE);
    assign bus_off     = (st == NODE_BUSOFF);

    assign bit_err   = hit_q.bit_e;
    assign stuff_err = hit_q.stuff_e;
    assign form_err  = hit_q.form_e;
    assign ack_err   = hit_q.ack_e;
    assign crc_err   = hit_q.crc_e;
endmodule

// File: rtl/cfc_checker.sv
`timescale 1ns/1ps
module cfc_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         smp,
    input logic         tx_bit,
    input logic         rx_bit,
    input logic         tx_active,
    input logic         in_arb,
    input logic         in_ack_slot,
    input logic         in_crc_delim,
    input logic         in_ack_delim,
    input logic         in_eof,
    input logic         six_same,
    input logic         stuff_drop,
    input logic         crc_ok,
    input logic         crc_chk,
    input logic         tx_ok,
    input logic         bit_err,
    input logic         stuff_err,
    input logic         form_err,
    input logic         ack_err,
    input logic         crc_err,
    input logic [W-1:0] tec,
    input logic         err_active,
    input logic         err_passive,
    input logic         bus_off
);
    localparam logic [W-1:0] TOP = '1;

    a_r1_bit_source: assert property (@(posedge clk) disable iff (rst)
        bit_err |-> $past(smp && tx_active && !in_arb && !in_ack_slot && (tx_bit != rx_bit)));

    a_r1_no_flag_idle: assert property (@(posedge clk) disable iff (rst)
        (!smp && !crc_chk) |=> !(bit_err || stuff_err || form_err || ack_err || crc_err));

    a_r2_stuff_source: assert property (@(posedge clk) disable iff (rst)
        stuff_err |-> $past(smp && six_same && !stuff_drop));

    a_r3_crc_source: assert property (@(posedge clk) disable iff (rst)
        crc_err |-> $past(crc_chk && !crc_ok));

    a_r4_form_source: assert property (@(posedge clk) disable iff (rst)
        form_err |-> $past(smp && !rx_bit && (in_crc_delim || in_ack_delim || in_eof)));

    a_r5_ack_source: assert property (@(posedge clk) disable iff (rst)
        ack_err |-> $past(smp && tx_active && in_ack_slot && rx_bit));

    a_r6_tec_hold_top: assert property (@(posedge clk) disable iff (rst)
        (tec == TOP && !tx_ok) |=> tec == TOP);

    a_r10_tec_no_drop: assert property (@(posedge clk) disable iff (rst)
        !tx_ok |=> tec >= $past(tec));

    a_r11_one_state: assert property (@(posedge clk) disable iff (rst)
        $onehot({err_active, err_passive, bus_off}));
endmodule

bind can_fault_conf cfc_checker #(.W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .smp          (smp),
    .tx_bit       (tx_bit),
    .rx_bit       (rx_bit),
    .tx_active    (tx_active),
    .in_arb       (in_arb),
    .in_ack_slot  (in_ack_slot),
    .in_crc_delim (in_crc_delim),
    .in_ack_delim (in_ack_delim),
    .in_eof       (in_eof),
    .six_same     (six_same),
    .stuff_drop   (stuff_drop),
    .crc_ok       (crc_ok),
    .crc_chk      (crc_chk),
    .tx_ok        (tx_ok),
    .bit_err      (bit_err),
    .stuff_err    (stuff_err),
    .form_err     (form_err),
    .ack_err      (ack_err),
    .crc_err      (crc_err),
    .tec          (tec),
    .err_active   (err_active),
    .err_passive  (err_passive),
    .bus_off      (bus_off)
);

// File: tb/sim_can_fault_conf.sv
`timescale 1ns/1ps
module sim_can_fault_conf;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp, tx_bit, rx_bit, tx_active, in_arb, in_ack_slot;
    logic in_crc_delim, in_ack_delim, in_eof, six_same, stuff_drop;
    logic crc_ok, crc_chk, post_flag, tx_ok, rx_ok;
    logic bit_err, stuff_err, form_err, ack_err, crc_err;
    logic [7:0] tec, rec;
    logic err_active, err_passive, bus_off;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    can_fault_conf u0 (
        .clk(clk), .rst(rst), .smp(smp), .tx_bit(tx_bit), .rx_bit(rx_bit),
        .tx_active(tx_active), .in_arb(in_arb), .in_ack_slot(in_ack_slot),
        .in_crc_delim(in_crc_delim), .in_ack_delim(in_ack_delim), .in_eof(in_eof),
        .six_same(six_same), .stuff_drop(stuff_drop), .crc_ok(crc_ok),
        .crc_chk(crc_chk), .post_flag(post_flag), .tx_ok(tx_ok), .rx_ok(rx_ok),
        .bit_err(bit_err), .stuff_err(stuff_err), .form_err(form_err),
        .ack_err(ack_err), .crc_err(crc_err), .tec(tec), .rec(rec),
        .err_active(err_active), .err_passive(err_passive), .bus_off(bus_off)
    );

    task automatic idle();
        smp = 0; tx_bit = 1; rx_bit = 1; tx_active = 0; in_arb = 0;
        in_ack_slot = 0; in_crc_delim = 0; in_ack_delim = 0; in_eof = 0;
        six_same = 0; stuff_drop = 0; crc_ok = 1; crc_chk = 0;
        post_flag = 0; tx_ok = 0; rx_ok = 0;
    endtask

    // one clock with the inputs already set; results visible on return
    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        repeat (2) @(posedge clk);
        #1;
        rst = 0;
    endtask

    task automatic bit_mismatch_tx();
        smp = 1; tx_active = 1; tx_bit = 0; rx_bit = 1;
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R13 tec", tec, 0);
        chk("R13 rec", rec, 0);
        chk("R13 active", err_active, 1);
        chk("R13 flags", {bit_err, stuff_err, form_err, ack_err, crc_err}, 0);
    endtask

    task automatic t_bit_err();
        do_reset();
        bit_mismatch_tx();
        chk("R1 bit_err", bit_err, 1);
        chk("R6 tec after bit error", tec, 8);
        tick();
        chk("R1 single pulse", bit_err, 0);
        smp = 1; tx_active = 1; in_arb = 1; tx_bit = 1; rx_bit = 0;
        tick();
        chk("R1 arbitration exempt", bit_err, 0);
        chk("R1 tec unchanged in arb", tec, 8);
        smp = 0; tx_active = 1; tx_bit = 0; rx_bit = 1;
        tick();
        chk("R1 no sample no flag", bit_err, 0);
        smp = 1; tx_active = 1; in_ack_slot = 1; tx_bit = 1; rx_bit = 0;
        tick();
        chk("R1 ack slot exempt", bit_err, 0);
        chk("R5 dominant ack no error", ack_err, 0);
        chk("R1 tec still 8", tec, 8);
    endtask

    task automatic t_stuff();
        do_reset();
        smp = 1; six_same = 1;
        tick();
        chk("R2 stuff_err", stuff_err, 1);
        chk("R7 rec +1", rec, 1);
        smp = 1; six_same = 1; stuff_drop = 1;
        tick();
        chk("R2 removed stuff ok", stuff_err, 0);
        chk("R7 rec still 1", rec, 1);
    endtask

    task automatic t_crc();
        do_reset();
        crc_chk = 1; crc_ok = 0;
        tick();
        chk("R3 crc_err", crc_err, 1);
        chk("R7 rec after crc", rec, 1);
        crc_chk = 1; crc_ok = 1;
        tick();
        chk("R3 crc match no flag", crc_err, 0);
        crc_ok = 0;
        tick();
        chk("R3 no strobe no flag", crc_err, 0);
        chk("R3 rec stays 1", rec, 1);
    endtask

    task automatic t_form();
        do_reset();
        smp = 1; in_eof = 1; rx_bit = 0;
        tick();
        chk("R4 eof dominant", form_err, 1);
        smp = 1; in_crc_delim = 1; rx_bit = 0;
        tick();
        chk("R4 crc delim dominant", form_err, 1);
        smp = 1; in_ack_delim = 1; rx_bit = 1;
        tick();
        chk("R4 recessive delim ok", form_err, 0);
        chk("R4 rec count", rec, 2);
    endtask

    task automatic t_ack();
        do_reset();
        smp = 1; tx_active = 1; in_ack_slot = 1; tx_bit = 1; rx_bit = 1;
        tick();
        chk("R5 ack_err", ack_err, 1);
        chk("R5 no bit_err in slot", bit_err, 0);
        chk("R6 tec after ack", tec, 8);
        smp = 1; tx_active = 0; in_ack_slot = 1; rx_bit = 1;
        tick();
        chk("R5 receiver no ack err", ack_err, 0);
    endtask

    task automatic t_tx_sat();
        do_reset();
        for (int i = 0; i < 15; i++) bit_mismatch_tx();
        chk("R6 tec 120", tec, 120);
        chk("R11 active at 120", err_active, 1);
        bit_mismatch_tx();
        chk("R6 tec 128", tec, 128);
        chk("R11 passive at 128", err_passive, 1);
        for (int i = 0; i < 16; i++) bit_mismatch_tx();
        chk("R6 tec saturates", tec, 255);
        chk("R11 bus_off", bus_off, 1);
        chk("R11 not passive when off", err_passive, 0);
        bit_mismatch_tx();
        chk("R6 tec held at 255", tec, 255);
        tx_ok = 1;
        tick();
        chk("R10 tec 254", tec, 254);
        chk("R11 back to passive", err_passive, 1);
    endtask

    task automatic t_rx_sat();
        do_reset();
        for (int i = 0; i < 127; i++) begin crc_chk = 1; crc_ok = 0; tick(); end
        chk("R7 rec 127", rec, 127);
        chk("R11 active rec 127", err_active, 1);
        crc_chk = 1; crc_ok = 0;
        tick();
        chk("R11 passive rec 128", err_passive, 1);
        for (int i = 0; i < 130; i++) begin crc_chk = 1; crc_ok = 0; tick(); end
        chk("R7 rec saturates", rec, 255);
        chk("R11 rec alone not bus_off", bus_off, 0);
        chk("R11 passive rec 255", err_passive, 1);
    endtask

    task automatic t_run();
        do_reset();
        for (int i = 0; i < 13; i++) begin smp = 1; rx_bit = 0; tick(); end
        chk("R8 13 dominant no change", tec + rec, 0);
        smp = 1; rx_bit = 0;
        tick();
        chk("R8 tec +8", tec, 8);
        chk("R8 rec +8", rec, 8);
        for (int i = 0; i < 13; i++) begin smp = 1; rx_bit = 0; tick(); end
        smp = 1; rx_bit = 1;
        tick();
        smp = 1; rx_bit = 0;
        tick();
        chk("R8 recessive restarts run", tec, 8);
        for (int i = 0; i < 13; i++) begin smp = 1; rx_bit = 0; tick(); end
        chk("R8 second run tec", tec, 16);
        chk("R8 second run rec", rec, 16);
    endtask

    task automatic t_post_flag();
        do_reset();
        smp = 1; post_flag = 1; rx_bit = 0;
        tick();
        chk("R9 rec +8", rec, 8);
        chk("R9 tec untouched", tec, 0);
        smp = 1; post_flag = 1; rx_bit = 1;
        tick();
        chk("R9 recessive no change", rec, 8);
    endtask

    task automatic t_success();
        do_reset();
        tx_ok = 1; rx_ok = 1;
        tick();
        chk("R10 tec floor", tec, 0);
        chk("R10 rec floor", rec, 0);
        bit_mismatch_tx();
        crc_chk = 1; crc_ok = 0;
        tick();
        tx_ok = 1;
        tick();
        chk("R10 tec 7", tec, 7);
        rx_ok = 1;
        tick();
        chk("R10 rec 0", rec, 0);
    endtask

    task automatic t_combined();
        do_reset();
        smp = 1; tx_active = 1; tx_bit = 0; rx_bit = 1; six_same = 1;
        tick();
        chk("R12 two classes one error", tec, 8);
        chk("R12 both flags bit", bit_err, 1);
        chk("R12 both flags stuff", stuff_err, 1);
        smp = 1; tx_active = 1; tx_bit = 0; rx_bit = 1; tx_ok = 1;
        tick();
        chk("R12 net +8-1", tec, 15);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_bit_err();
        t_stuff();
        t_crc();
        t_form();
        t_ack();
        t_tx_sat();
        t_rx_sat();
        t_run();
        t_post_flag();
        t_success();
        t_combined();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule